// File: doc/BRIEF.md
# Multi-Mode Bus-Master Transfer Channel

This block is one transfer channel that takes the system bus from the processor and moves bytes between a peripheral and memory. Software programs a start address, a count and a service policy through a small write port. A peripheral then asks for service on a request line. The channel raises a bus hold request, waits for the grant, and runs byte cycles. Each byte cycle carries an address and a matched pair of read and write strobes. During each byte cycle the channel also acknowledges the peripheral.

The four policies differ only in when the bus is handed back:
- after each byte;
- only once the programmed count runs out;
- whenever the peripheral withdraws its request, keeping its place so it can resume later;
- never, because the channel simply relays request and grant for a downstream bus master.

The count is one less than the number of bytes to move. When the last byte is moved, the channel flags it for one cycle and disables itself.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is asserted, every output (hold_req, dev_ack, mem_addr, all four strobes, tc) is low.
- R2: A write with cfg_sel=2'd0 loads the control word. Bits [1:0] select the policy: 00 on-request, 01 per-byte, 10 burst-to-end, 11 relay. Bit 2 selects the direction: 1 moves device to memory, 0 moves memory to device. Bit 3 is the enable. A write with cfg_sel=2'd1 loads the start address, and a write with cfg_sel=2'd2 loads the count.
- R3: hold_req rises when an enabled non-relay channel sees dev_req. No strobe is issued unless hold_ack was high in the cycle before.
- R4: During a byte cycle, device-to-memory asserts io_rd together with mem_wr, and memory-to-device asserts mem_rd together with io_wr. dev_ack is high in every byte cycle.
- R5: mem_addr presents the programmed start address on the first byte and rises by one on each following byte. A count of N moves N+1 bytes.
- R6: tc is high for exactly one cycle, during the last byte. The channel then ignores dev_req until it is reprogrammed.
- R7: In per-byte policy, one byte is moved per request and then the bus is released. Another byte needs dev_req to go low and return, with hold_ack low in between.
- R8: In burst-to-end policy, a request lasting one cycle is enough to move the whole count.
- R9: In on-request policy, the bus is released after the byte during which dev_req is seen low. When dev_req returns, transfers resume at the next address with the remaining count.
- R10: In relay policy, hold_req follows dev_req and dev_ack equals dev_req AND hold_ack. No strobe and no address is produced.
- R11: hold_req is low in the cycle right after the last byte of a service period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 address, 2 count |
| cfg_wdata | input | DW | Register write data |
| dev_req | input | 1 | Peripheral (or downstream master) request |
| dev_ack | output | 1 | Peripheral acknowledge |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address during a byte cycle, zero otherwise |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| tc | output | 1 | Last-byte flag |

## Verification
The hardest case to reach is an on-request service period that breaks off in the middle of the count and resumes later. The request must fall in exactly the right byte cycle, and the address and count must survive the idle gap. The bench gets there by watching the byte cycles at the ports and dropping dev_req right after a chosen byte has been seen. It then idles and raises the request again, and expects the remaining addresses to continue without a gap. A similar gate protects the per-byte policy: a request held high must not start a second byte, and that is checked by keeping dev_req asserted over many cycles.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int DW = (AW > CW) ? AW : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          dev_req,
  output logic          dev_ack,
  output logic          hold_req,
  input  logic          hold_ack,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_rd,
  output logic          io_wr,
  output logic          tc
);
  localparam logic [1:0] POL_DEMAND = 2'b00;
  localparam logic [1:0] POL_SINGLE = 2'b01;
  localparam logic [1:0] POL_BLOCK  = 2'b10;
  localparam logic [1:0] POL_RELAY  = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_XFER} state_t;

  state_t        state_q, state_d;
  logic [1:0]    mode_q;
  logic          dir_q, en_q, armed_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;

  wire relay  = en_q && (mode_q == POL_RELAY);
  wire xfer   = (state_q == S_XFER) && !relay;
  wire last   = xfer && (cnt_q == '0);
  wire demand = (mode_q == POL_DEMAND);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (en_q && !relay && dev_req && armed_q && !hold_ack) state_d = S_HOLD;
      S_HOLD: begin
        if (!en_q || relay || (demand && !dev_req)) state_d = S_IDLE;
        else if (hold_ack)                          state_d = S_XFER;
      end
      S_XFER: begin
        if (relay || last || mode_q == POL_SINGLE) state_d = S_IDLE;
        else if (demand && !dev_req)               state_d = S_IDLE;
        else if (!hold_ack)                        state_d = S_HOLD;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= POL_DEMAND;
      dir_q   <= 1'b0;
      en_q    <= 1'b0;
      armed_q <= 1'b1;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (xfer) begin
        addr_q <= addr_q + 1'b1;
        cnt_q  <= cnt_q - 1'b1;
        if (last) en_q <= 1'b0;
      end
      if (xfer && mode_q == POL_SINGLE) armed_q <= 1'b0;
      else if (!dev_req)                armed_q <= 1'b1;
      if (cfg_we) begin
        unique case (cfg_sel)
          2'd0: begin
            mode_q  <= cfg_wdata[1:0];
            dir_q   <= cfg_wdata[2];
            en_q    <= cfg_wdata[3];
            armed_q <= 1'b1;
          end
          2'd1: addr_q <= cfg_wdata[AW-1:0];
          2'd2: cnt_q  <= cfg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign hold_req = (state_q != S_IDLE && !relay) || (relay && dev_req);
  assign dev_ack  = xfer || (relay && dev_req && hold_ack);
  assign mem_addr = xfer ? addr_q : '0;
  assign mem_wr   = xfer && dir_q;
  assign io_rd    = xfer && dir_q;
  assign mem_rd   = xfer && !dir_q;
  assign io_wr    = xfer && !dir_q;
  assign tc       = last;
endmodule

// File: rtl/dma_chan_checks.sv
module dma_chan_checks #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    mode_q,
  input logic          en_q,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          hold_req,
  input logic          hold_ack,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          tc
);
  wire strobe = mem_rd || mem_wr;

  p_strobe_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(hold_ack) && hold_req);

  p_ack_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> dev_ack && (io_rd || io_wr));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe) && !$past(cfg_we)) |-> mem_addr == $past(mem_addr) + 1'b1);

  p_tc_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  p_per_byte_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && mode_q == 2'b01 && !cfg_we) |=> !dev_ack && !hold_req);

  p_relay_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q == 2'b11) |-> !strobe && !io_rd && !io_wr && mem_addr == '0
                                  && hold_req == dev_req);

  p_release_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !cfg_we) |=> !hold_req && !dev_ack);
endmodule

bind dma_chan_engine dma_chan_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode_q(mode_q), .en_q(en_q),
  .dev_req(dev_req), .dev_ack(dev_ack), .hold_req(hold_req), .hold_ack(hold_ack),
  .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
  .io_wr(io_wr), .tc(tc)
);

// File: tb/test_dma_chan_engine.sv
`timescale 1ns/1ps
module test_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        dev_req = 1'b0;
  logic        dev_ack, hold_req;
  logic        hold_ack = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, io_rd, io_wr, tc;

  always #10 clk = ~clk;

  dma_chan_engine i_dma_chan_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dev_req(dev_req), .dev_ack(dev_ack), .hold_req(hold_req), .hold_ack(hold_ack),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .tc(tc)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0, xfer_total = 0, tc_total = 0, pair_err = 0, nohold_err = 0;
  int last_strobe = 0, hold_fall = 0;
  logic [15:0] log_addr [256];
  logic        log_dir  [256];
  logic [15:0] tc_addr = '0;
  logic        prev_hold = 1'b0;

  // bus monitor and processor grant model
  initial forever begin
    @(negedge clk);
    cyc++;
    if (mem_rd || mem_wr) begin
      log_addr[xfer_total[7:0]] = mem_addr;
      log_dir[xfer_total[7:0]]  = mem_wr;
      if (!(mem_wr ? (io_rd && !io_wr && !mem_rd) : (io_wr && !io_rd)) || !dev_ack) pair_err++;
      if (!hold_ack) nohold_err++;
      last_strobe = cyc;
      xfer_total++;
    end
    if (tc) begin tc_total++; tc_addr = mem_addr; end
    if (prev_hold && !hold_req) hold_fall = cyc;
    prev_hold = hold_req;
    hold_ack  = hold_req;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    tick(); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick(); cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    #5;
    chk({hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc} == 7'b0 && mem_addr == 16'h0,
        "R1 outputs in reset", {hold_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, tc}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_block();
    int b, tb0;
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'd2);
    wr(2'd0, 16'b1110);
    b = xfer_total; tb0 = tc_total;
    tick(); dev_req = 1'b1;
    tick(); dev_req = 1'b0;
    chk(hold_req == 1'b1, "R3 hold raised on request", hold_req, 1);
    repeat (20) tick();
    chk(xfer_total - b == 3, "R8 R5 byte count for count=2", xfer_total - b, 3);
    for (int i = 0; i < 3; i++) begin
      chk(log_addr[b + i] == 16'h0100 + i[15:0], "R2 R5 address sequence", log_addr[b + i], 16'h0100 + i);
      chk(log_dir[b + i] == 1'b1, "R4 device-to-memory strobes", log_dir[b + i], 1);
    end
    chk(tc_total - tb0 == 1 && tc_addr == 16'h0102, "R6 single tc on last byte", tc_total - tb0, 1);
    chk(hold_fall == last_strobe + 1, "R11 hold drops after last byte", hold_fall, last_strobe + 1);
    dev_req = 1'b1;
    repeat (10) tick();
    chk(xfer_total - b == 3 && hold_req == 1'b0, "R6 request ignored after tc", xfer_total - b, 3);
    dev_req = 1'b0;
  endtask

  task automatic t_single();
    int b;
    wr(2'd1, 16'h0020);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'b1001);
    b = xfer_total;
    tick(); dev_req = 1'b1;
    repeat (20) tick();
    chk(xfer_total - b == 1, "R7 one byte per request", xfer_total - b, 1);
    chk(log_addr[b] == 16'h0020 && log_dir[b] == 1'b0, "R4 memory-to-device strobes", log_addr[b], 16'h0020);
    chk(hold_fall == last_strobe + 1 && hold_req == 1'b0, "R7 R11 bus released after byte", hold_fall, last_strobe + 1);
    dev_req = 1'b0;
    repeat (2) tick();
    dev_req = 1'b1;
    repeat (10) tick();
    chk(xfer_total - b == 2 && log_addr[b + 1] == 16'h0021, "R7 fresh request moves next byte",
        xfer_total - b, 2);
    dev_req = 1'b0;
  endtask

  task automatic t_demand();
    int b, tb0;
    wr(2'd1, 16'h0040);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'b1100);
    b = xfer_total; tb0 = tc_total;
    tick(); dev_req = 1'b1;
    for (int k = 0; k < 50 && xfer_total - b < 2; k++) tick();
    dev_req = 1'b0;
    repeat (6) tick();
    chk(xfer_total - b == 2, "R9 stops when request drops", xfer_total - b, 2);
    chk(hold_req == 1'b0, "R9 bus released while paused", hold_req, 0);
    chk(tc_total - tb0 == 0, "R9 no tc while paused", tc_total - tb0, 0);
    dev_req = 1'b1;
    repeat (20) tick();
    dev_req = 1'b0;
    chk(xfer_total - b == 6, "R9 resumes remaining count", xfer_total - b, 6);
    for (int i = 2; i < 6; i++)
      chk(log_addr[b + i] == 16'h0040 + i[15:0], "R9 resumed address", log_addr[b + i], 16'h0040 + i);
    chk(tc_total - tb0 == 1 && tc_addr == 16'h0045, "R6 tc at end of demand", tc_addr, 16'h0045);
  endtask

  task automatic t_relay();
    int b;
    wr(2'd0, 16'b1011);
    b = xfer_total;
    tick(); dev_req = 1'b1; #1;
    chk(hold_req == 1'b1 && dev_ack == 1'b0, "R10 request relayed", {hold_req, dev_ack}, 2'b10);
    tick();
    chk(dev_ack == 1'b1 && mem_addr == 16'h0, "R10 grant relayed, no address", dev_ack, 1);
    repeat (5) tick();
    dev_req = 1'b0; #1;
    chk(hold_req == 1'b0 && dev_ack == 1'b0, "R10 release relayed", {hold_req, dev_ack}, 0);
    chk(xfer_total - b == 0, "R10 no strobes", xfer_total - b, 0);
    wr(2'd0, 16'b0000);
  endtask

  initial begin
    t_reset();
    t_block();
    t_single();
    t_demand();
    t_relay();
    repeat (3) tick();
    chk(pair_err == 0, "R4 strobe pairing and ack", pair_err, 0);
    chk(nohold_err == 0, "R3 no strobe without grant", nohold_err, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule